// File: doc/BRIEF.md
# Video Sync Port Edge and Field Detector

This block manages one bidirectional video synchronization port and turns it into three internal timing signals: a one-cycle line strobe, a one-cycle frame strobe and a field level. Depending on a two-bit port mode, the horizontal and vertical sync pins are either inputs or are driven from gate signals produced elsewhere on the chip. The strobes are derived from whichever source currently feeds each pin. A field-change interrupt pulse is raised on selected transitions of the field level.

All sync sources are oversampled in the system clock domain. Before edge detection they pass through a synchronizer of `SYNC_STAGES` flops. A single configuration word, written through `cfg_wr`/`cfg_wdata`, selects the pin roles, the output inversions, one of eight strobe and field derivation modes, and the interrupt edges. The forced-toggle modes keep the field level alternating from frame to frame, and correct it to the measured value only after two consecutive frames disagree. This is tracked by a small state machine with the states TRK_IDLE, TRK_LOCKED and TRK_SUSPECT.

Top module: `vsync_port`

## Requirements
- R1: After reset the configuration word is 0. Both output enables, both pin drives, `h_strobe`, `v_strobe`, `field_out` and `field_irq` are 0.
- R2: A cycle with `cfg_wr` = 1 loads `cfg_wdata` into the configuration word at the clock edge. The fields are: bits [1:0] port mode, bit 2 HS invert, bit 3 VS invert, bits [6:4] sync mode, bits [8:7] interrupt edge select.
- R3: The port mode sets the enables combinationally. 00 disables both pins. 01 and 11 enable both pins. 10 enables only HS. `vs_oe` is never 1 while `hs_oe` is 0.
- R4: When HS is enabled, `hs_drive` is the selected source XOR the HS invert bit. Mode 01 selects `sca_hgate`, mode 10 selects `fmem_reset` and mode 11 selects `scb_hgate`. `vs_drive` follows `sca_vgate` (mode 01) or `scb_vgate` (mode 11) XOR the VS invert bit. A pin that is not enabled drives 0.
- R5: Each sync source is the pin input while that pin is an input, and the pin's own drive value while it is an output. A source change made before a clock edge shows its strobe in the cycle after the third rising edge.
- R6: In every sync mode except 111, `h_strobe` is a single-cycle pulse for each rising edge of the HS source, and rises on nothing else.
- R7: `v_strobe` pulses once per VS rising edge in sync modes 000, 010 and 100, and once per VS falling edge in modes 001, 011 and 101. It pulses on both edges in mode 110.
- R8: In sync modes 000 and 001, `field_out` takes the HS level present at the VS edge that fires `v_strobe`.
- R9: In sync modes 010 and 011, `field_out` inverts on every `v_strobe`. At each VS falling edge the HS level is compared with the resulting value. After two consecutive mismatches, `field_out` is loaded with the HS level.
- R10: In sync mode 101, `field_out` inverts on every `v_strobe`. In mode 100 it keeps its value.
- R11: In sync mode 110, `field_out` follows the synchronized VS level.
- R12: In sync mode 111 with `code_disable` = 0, the pins are ignored. `h_strobe` and `v_strobe` pulse on rising edges of `code_h` and `code_v`, and `field_out` follows `code_field`. With `code_disable` = 1, mode 111 behaves as mode 000.
- R13: `field_irq` is a single-cycle pulse one cycle after `field_out` changes. Interrupt select 00 gives no pulse, 01 pulses on a rise, 10 on a fall and 11 on both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Configuration word to load |
| hs_pin | input | 1 | HS pin input value |
| vs_pin | input | 1 | VS pin input value |
| hs_oe | output | 1 | HS pin output enable |
| vs_oe | output | 1 | VS pin output enable |
| hs_drive | output | 1 | HS pin output value |
| vs_drive | output | 1 | VS pin output value |
| sca_hgate | input | 1 | Scaler A horizontal gate |
| sca_vgate | input | 1 | Scaler A vertical gate |
| scb_hgate | input | 1 | Scaler B horizontal gate |
| scb_vgate | input | 1 | Scaler B vertical gate |
| fmem_reset | input | 1 | Field memory reset to drive on HS |
| code_h | input | 1 | Decoded embedded-code line flag |
| code_v | input | 1 | Decoded embedded-code frame flag |
| code_field | input | 1 | Decoded embedded-code field level |
| code_disable | input | 1 | Forces mode 111 back to mode 000 |
| h_strobe | output | 1 | Line strobe |
| v_strobe | output | 1 | Frame strobe |
| field_out | output | 1 | Field level (1 odd, 0 even) |
| field_irq | output | 1 | Field-change interrupt pulse |

## Verification
A chained vector table moves HS and VS through rising and falling transitions. Some steps move HS alone, some move VS alone, and some move both together, so a mode that fires on the wrong VS edge or samples HS at the wrong moment gives a different strobe count or field value. The forced-toggle sequence first creates a single HS mismatch, which must be tolerated, and then a second one, which must correct the field. A free-toggle run would end in a different value there. Directed tests drive the scaler gates while the pins carry conflicting values, to show which source feeds the strobes. They also pulse the embedded flags with `code_disable` at both values, and count the cycle in which the first strobe appears.

// File: rtl/vsync_port_pkg.sv
package vsync_port_pkg;

    typedef enum logic [1:0] {
        PM_ALL_INPUT = 2'b00,
        PM_SCALER_A  = 2'b01,
        PM_FIELD_MEM = 2'b10,
        PM_SCALER_B  = 2'b11
    } port_mode_e;

    typedef enum logic [2:0] {
        SM_RISE_DIRECT = 3'd0,
        SM_FALL_DIRECT = 3'd1,
        SM_RISE_FORCED = 3'd2,
        SM_FALL_FORCED = 3'd3,
        SM_RISE_HOLD   = 3'd4,
        SM_FALL_FREE   = 3'd5,
        SM_FRAME_LEVEL = 3'd6,
        SM_EMBEDDED    = 3'd7
    } sync_mode_e;

    typedef enum logic [1:0] {
        IE_NONE = 2'b00,
        IE_RISE = 2'b01,
        IE_FALL = 2'b10,
        IE_BOTH = 2'b11
    } irq_edge_e;

    typedef enum logic [1:0] {
        TRK_IDLE    = 2'd0,
        TRK_LOCKED  = 2'd1,
        TRK_SUSPECT = 2'd2
    } track_state_e;

    typedef struct packed {
        irq_edge_e  irq_edge;
        sync_mode_e sync_mode;
        logic       vs_inv;
        logic       hs_inv;
        port_mode_e port_mode;
    } port_cfg_t;

    localparam int CFG_W = $bits(port_cfg_t);

endpackage

// File: rtl/vsync_port_pins.sv
module vsync_port_pins
    import vsync_port_pkg::*;
(
    input  port_mode_e port_mode,
    input  logic       hs_inv,
    input  logic       vs_inv,
    input  logic       hs_pin,
    input  logic       vs_pin,
    input  logic       sca_hgate,
    input  logic       sca_vgate,
    input  logic       scb_hgate,
    input  logic       scb_vgate,
    input  logic       fmem_reset,
    output logic       hs_oe,
    output logic       vs_oe,
    output logic       hs_drive,
    output logic       vs_drive,
    output logic       hs_src,
    output logic       vs_src
);

    logic hs_pick;
    logic vs_pick;

    // Pin roles and the raw signal for each driven pin
    always_comb begin
        hs_oe   = 1'b0;
        vs_oe   = 1'b0;
        hs_pick = 1'b0;
        vs_pick = 1'b0;
        unique case (port_mode)
            PM_ALL_INPUT: begin
                hs_oe = 1'b0;
            end
            PM_SCALER_A: begin
                hs_oe   = 1'b1;
                vs_oe   = 1'b1;
                hs_pick = sca_hgate;
                vs_pick = sca_vgate;
            end
            PM_FIELD_MEM: begin
                hs_oe   = 1'b1;
                hs_pick = fmem_reset;
            end
            PM_SCALER_B: begin
                hs_oe   = 1'b1;
                vs_oe   = 1'b1;
                hs_pick = scb_hgate;
                vs_pick = scb_vgate;
            end
            default: begin
                hs_oe = 1'b0;
            end
        endcase
    end

    assign hs_drive = hs_oe & (hs_pick ^ hs_inv);
    assign vs_drive = vs_oe & (vs_pick ^ vs_inv);

    // Internal timing follows whatever the pin carries
    assign hs_src = hs_oe ? hs_drive : hs_pin;
    assign vs_src = vs_oe ? vs_drive : vs_pin;

endmodule

// File: rtl/vsync_port_edge.sv
module vsync_port_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic level,
    output logic rise,
    output logic fall
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q[0] <= d_in;
            prev_q     <= chain_q[LAST];
            for (int i = 1; i <= LAST; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign level = chain_q[LAST];
    assign rise  = chain_q[LAST] & ~prev_q;
    assign fall  = ~chain_q[LAST] & prev_q;

endmodule

// File: rtl/vsync_port_field.sv
module vsync_port_field
    import vsync_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sync_mode_e sync_mode,
    input  logic       code_disable,
    input  logic       hs_level,
    input  logic       hs_rise,
    input  logic       vs_level,
    input  logic       vs_rise,
    input  logic       vs_fall,
    input  logic       code_h,
    input  logic       code_v,
    input  logic       code_field,
    output logic       h_strobe,
    output logic       v_strobe,
    output logic       field_out
);

    track_state_e trk_q, trk_nxt;
    sync_mode_e   eff_mode;
    logic         code_h_q, code_v_q;
    logic         h_evt, v_evt, fld_nxt, toggled, forced;

    assign eff_mode = (sync_mode == SM_EMBEDDED && code_disable) ? SM_RISE_DIRECT : sync_mode;
    assign forced   = (eff_mode == SM_RISE_FORCED) || (eff_mode == SM_FALL_FORCED);

    // Next-state and next-output decisions
    always_comb begin
        h_evt   = hs_rise;
        v_evt   = 1'b0;
        fld_nxt = field_out;
        trk_nxt = trk_q;
        toggled = field_out;
        unique case (eff_mode)
            SM_RISE_DIRECT: begin
                v_evt = vs_rise;
                if (vs_rise) fld_nxt = hs_level;
            end
            SM_FALL_DIRECT: begin
                v_evt = vs_fall;
                if (vs_fall) fld_nxt = hs_level;
            end
            SM_RISE_FORCED, SM_FALL_FORCED: begin
                v_evt   = (eff_mode == SM_RISE_FORCED) ? vs_rise : vs_fall;
                toggled = v_evt ? ~field_out : field_out;
                fld_nxt = toggled;
                if (trk_q == TRK_IDLE) trk_nxt = TRK_LOCKED;
                if (vs_fall) begin
                    if (hs_level == toggled) begin
                        trk_nxt = TRK_LOCKED;
                    end else if (trk_q == TRK_SUSPECT) begin
                        fld_nxt = hs_level;
                        trk_nxt = TRK_LOCKED;
                    end else begin
                        trk_nxt = TRK_SUSPECT;
                    end
                end
            end
            SM_RISE_HOLD: begin
                v_evt = vs_rise;
            end
            SM_FALL_FREE: begin
                v_evt = vs_fall;
                if (vs_fall) fld_nxt = ~field_out;
            end
            SM_FRAME_LEVEL: begin
                v_evt   = vs_rise | vs_fall;
                fld_nxt = vs_level;
            end
            SM_EMBEDDED: begin
                h_evt   = code_h & ~code_h_q;
                v_evt   = code_v & ~code_v_q;
                fld_nxt = code_field;
            end
            default: begin
                v_evt = 1'b0;
            end
        endcase
        if (!forced) trk_nxt = TRK_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= TRK_IDLE;
        else        trk_q <= trk_nxt;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_strobe  <= 1'b0;
            v_strobe  <= 1'b0;
            field_out <= 1'b0;
            code_h_q  <= 1'b0;
            code_v_q  <= 1'b0;
        end else begin
            h_strobe  <= h_evt;
            v_strobe  <= v_evt;
            field_out <= fld_nxt;
            code_h_q  <= code_h;
            code_v_q  <= code_v;
        end
    end

endmodule

// File: rtl/vsync_port_irq.sv
module vsync_port_irq
    import vsync_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  irq_edge_e irq_edge,
    input  logic      field_in,
    output logic      field_irq
);

    logic prev_q;
    logic fld_rise, fld_fall;

    assign fld_rise = field_in & ~prev_q;
    assign fld_fall = ~field_in & prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= 1'b0;
            field_irq <= 1'b0;
        end else begin
            prev_q    <= field_in;
            field_irq <= (fld_rise & irq_edge[0]) | (fld_fall & irq_edge[1]);
        end
    end

endmodule

// File: rtl/vsync_port.sv
module vsync_port
    import vsync_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             hs_pin,
    input  logic             vs_pin,
    output logic             hs_oe,
    output logic             vs_oe,
    output logic             hs_drive,
    output logic             vs_drive,
    input  logic             sca_hgate,
    input  logic             sca_vgate,
    input  logic             scb_hgate,
    input  logic             scb_vgate,
    input  logic             fmem_reset,
    input  logic             code_h,
    input  logic             code_v,
    input  logic             code_field,
    input  logic             code_disable,
    output logic             h_strobe,
    output logic             v_strobe,
    output logic             field_out,
    output logic             field_irq
);

    port_cfg_t cfg_q;
    logic      hs_src, vs_src;
    logic      hs_lvl, hs_rise, hs_fall;
    logic      vs_lvl, vs_rise, vs_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= port_cfg_t'(cfg_wdata);
    end

    vsync_port_pins u_pins (
        .port_mode (cfg_q.port_mode),
        .hs_inv    (cfg_q.hs_inv),
        .vs_inv    (cfg_q.vs_inv),
        .hs_pin    (hs_pin),
        .vs_pin    (vs_pin),
        .sca_hgate (sca_hgate),
        .sca_vgate (sca_vgate),
        .scb_hgate (scb_hgate),
        .scb_vgate (scb_vgate),
        .fmem_reset(fmem_reset),
        .hs_oe     (hs_oe),
        .vs_oe     (vs_oe),
        .hs_drive  (hs_drive),
        .vs_drive  (vs_drive),
        .hs_src    (hs_src),
        .vs_src    (vs_src)
    );

    vsync_port_edge #(.STAGES(SYNC_STAGES)) u_hs_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (hs_src),
        .level(hs_lvl),
        .rise (hs_rise),
        .fall (hs_fall)
    );

    vsync_port_edge #(.STAGES(SYNC_STAGES)) u_vs_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (vs_src),
        .level(vs_lvl),
        .rise (vs_rise),
        .fall (vs_fall)
    );

    vsync_port_field u_field (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_mode   (cfg_q.sync_mode),
        .code_disable(code_disable),
        .hs_level    (hs_lvl),
        .hs_rise     (hs_rise),
        .vs_level    (vs_lvl),
        .vs_rise     (vs_rise),
        .vs_fall     (vs_fall),
        .code_h      (code_h),
        .code_v      (code_v),
        .code_field  (code_field),
        .h_strobe    (h_strobe),
        .v_strobe    (v_strobe),
        .field_out   (field_out)
    );

    vsync_port_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_edge (cfg_q.irq_edge),
        .field_in (field_out),
        .field_irq(field_irq)
    );

endmodule

// File: rtl/vsync_port_checker.sv
module vsync_port_checker
    import vsync_port_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input port_cfg_t cfg,
    input logic      hs_oe,
    input logic      vs_oe,
    input logic      h_strobe,
    input logic      v_strobe,
    input logic      field_out,
    input logic      field_irq
);

    AST_INPUT_MODE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.port_mode == PM_ALL_INPUT) |-> (!hs_oe && !vs_oe)); // R3
    AST_VS_OE_NEEDS_HS: assert property (@(posedge clk) disable iff (!rst_n)
        vs_oe |-> hs_oe); // R3
    AST_HSTROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        h_strobe |=> !h_strobe); // R6
    AST_VSTROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        v_strobe |=> !v_strobe); // R7
    AST_HOLD_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg.sync_mode) == SM_RISE_HOLD) |-> $stable(field_out)); // R10
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg.irq_edge) == IE_NONE) |-> !field_irq); // R13
    AST_IRQ_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        field_irq |-> ($past(field_out) != $past(field_out, 2))); // R13

endmodule

bind vsync_port vsync_port_checker i_vsync_port_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg_q),
    .hs_oe    (hs_oe),
    .vs_oe    (vs_oe),
    .h_strobe (h_strobe),
    .v_strobe (v_strobe),
    .field_out(field_out),
    .field_irq(field_irq)
);

// File: tb/test_vsync_port.sv
`timescale 1ns/1ps
module test_vsync_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [8:0] cfg_wdata = '0;
    logic       hs_pin = 1'b0, vs_pin = 1'b0;
    logic       hs_oe, vs_oe, hs_drive, vs_drive;
    logic       sca_hgate = 1'b0, sca_vgate = 1'b0, scb_hgate = 1'b0, scb_vgate = 1'b0;
    logic       fmem_reset = 1'b0;
    logic       code_h = 1'b0, code_v = 1'b0, code_field = 1'b0, code_disable = 1'b0;
    logic       h_strobe, v_strobe, field_out, field_irq;

    int n_checks = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    vsync_port i_vsync_port (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .hs_pin(hs_pin), .vs_pin(vs_pin), .hs_oe(hs_oe), .vs_oe(vs_oe),
        .hs_drive(hs_drive), .vs_drive(vs_drive),
        .sca_hgate(sca_hgate), .sca_vgate(sca_vgate),
        .scb_hgate(scb_hgate), .scb_vgate(scb_vgate), .fmem_reset(fmem_reset),
        .code_h(code_h), .code_v(code_v), .code_field(code_field),
        .code_disable(code_disable), .h_strobe(h_strobe), .v_strobe(v_strobe),
        .field_out(field_out), .field_irq(field_irq)
    );

    // {irq_sel, sync_mode, 4'b0 (inv/port), hs, vs, exp_h, exp_v, exp_field, exp_irq}
    localparam int NV = 23;
    localparam logic [17:0] VEC [NV] = '{
        {2'd1, 3'd0, 4'd0, 1'b1, 1'b0, 2'd1, 2'd0, 1'b0, 2'd0},
        {2'd1, 3'd0, 4'd0, 1'b1, 1'b1, 2'd0, 2'd1, 1'b1, 2'd1},
        {2'd1, 3'd0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 2'd0},
        {2'd2, 3'd1, 4'd0, 1'b0, 1'b1, 2'd0, 2'd0, 1'b1, 2'd0},
        {2'd2, 3'd1, 4'd0, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, 2'd1},
        {2'd3, 3'd5, 4'd0, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 2'd0},
        {2'd3, 3'd5, 4'd0, 1'b0, 1'b0, 2'd0, 2'd1, 1'b1, 2'd1},
        {2'd3, 3'd5, 4'd0, 1'b1, 1'b1, 2'd1, 2'd0, 1'b1, 2'd0},
        {2'd3, 3'd5, 4'd0, 1'b1, 1'b0, 2'd0, 2'd1, 1'b0, 2'd1},
        {2'd3, 3'd4, 4'd0, 1'b0, 1'b1, 2'd0, 2'd1, 1'b0, 2'd0},
        {2'd3, 3'd4, 4'd0, 1'b1, 1'b0, 2'd1, 2'd0, 1'b0, 2'd0},
        {2'd3, 3'd6, 4'd0, 1'b1, 1'b1, 2'd0, 2'd1, 1'b1, 2'd1},
        {2'd0, 3'd6, 4'd0, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, 2'd0},
        {2'd0, 3'd3, 4'd0, 1'b1, 1'b1, 2'd1, 2'd0, 1'b0, 2'd0},
        {2'd0, 3'd3, 4'd0, 1'b1, 1'b0, 2'd0, 2'd1, 1'b1, 2'd0},
        {2'd0, 3'd3, 4'd0, 1'b1, 1'b1, 2'd0, 2'd0, 1'b1, 2'd0},
        {2'd0, 3'd3, 4'd0, 1'b1, 1'b0, 2'd0, 2'd1, 1'b0, 2'd0},
        {2'd0, 3'd3, 4'd0, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 2'd0},
        {2'd0, 3'd3, 4'd0, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, 2'd0},
        {2'd0, 3'd3, 4'd0, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 2'd0},
        {2'd0, 3'd3, 4'd0, 1'b0, 1'b0, 2'd0, 2'd1, 1'b1, 2'd0},
        {2'd0, 3'd2, 4'd0, 1'b0, 1'b1, 2'd0, 2'd1, 1'b0, 2'd0},
        {2'd0, 3'd2, 4'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [8:0] val);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic window(input int n, output int nh, output int nv, output int ni);
        nh = 0; nv = 0; ni = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            nh += int'(h_strobe);
            nv += int'(v_strobe);
            ni += int'(field_irq);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        int nh, nv, ni, ah, av, ai;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "hs_oe", hs_oe, 0);
        check("R1", "vs_oe", vs_oe, 0);
        check("R1", "hs_drive", hs_drive, 0);
        check("R1", "strobes", h_strobe | v_strobe, 0);
        check("R1", "field_out", field_out, 0);
        check("R1", "field_irq", field_irq, 0);

        // Vector table: R2 field layout used to build each word
        for (int i = 0; i < NV; i++) begin
            write_cfg(VEC[i][17:9]);
            hs_pin = VEC[i][8];
            vs_pin = VEC[i][7];
            window(6, nh, nv, ni);
            check("R6", $sformatf("vec%0d h_strobe count", i), nh, int'(VEC[i][6:5]));
            check("R7", $sformatf("vec%0d v_strobe count", i), nv, int'(VEC[i][4:3]));
            check("R8/R9/R10/R11", $sformatf("vec%0d field_out", i), field_out, int'(VEC[i][2]));
            check("R13", $sformatf("vec%0d field_irq count", i), ni, int'(VEC[i][1:0]));
        end

        // R5 latency and R6 pulse width
        @(negedge clk);
        hs_pin = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            check("R5", $sformatf("h_strobe at cycle %0d", k), h_strobe, (k == 3) ? 1 : 0);
        end
        hs_pin = 1'b0;

        // R3 and R4 pin roles and polarity
        write_cfg(9'b00_000_0_0_01);
        check("R3", "mode01 hs_oe", hs_oe, 1);
        check("R3", "mode01 vs_oe", vs_oe, 1);
        sca_hgate = 1'b1; #1;
        check("R4", "mode01 hs_drive", hs_drive, 1);
        check("R4", "mode01 vs_drive", vs_drive, 0);
        write_cfg(9'b00_000_1_1_01);
        check("R4", "inverted hs_drive", hs_drive, 0);
        check("R4", "inverted vs_drive", vs_drive, 1);
        fmem_reset = 1'b1;
        write_cfg(9'b00_000_0_0_10);
        check("R3", "mode10 hs_oe", hs_oe, 1);
        check("R3", "mode10 vs_oe", vs_oe, 0);
        check("R4", "mode10 hs_drive", hs_drive, 1);
        write_cfg(9'b00_000_0_0_11);
        scb_vgate = 1'b1; #1;
        check("R4", "mode11 hs_drive", hs_drive, 0);
        check("R4", "mode11 vs_drive", vs_drive, 1);
        sca_hgate = 1'b0; fmem_reset = 1'b0; scb_vgate = 1'b0;
        write_cfg(9'b00_000_0_0_00);
        check("R3", "mode00 enables", hs_oe + vs_oe, 0);

        // R5 source selection: gates feed strobes, pins ignored
        write_cfg(9'b00_000_0_0_01);
        window(6, nh, nv, ni);
        hs_pin = 1'b1;
        window(6, nh, nv, ni);
        check("R5", "pin ignored while output", nh, 0);
        sca_hgate = 1'b1;
        window(6, nh, nv, ni);
        check("R5", "gate drives h_strobe", nh, 1);
        sca_vgate = 1'b1;
        window(6, nh, nv, ni);
        check("R5", "gate drives v_strobe", nv, 1);
        check("R8", "field from gate HS", field_out, 1);
        sca_hgate = 1'b0; sca_vgate = 1'b0; hs_pin = 1'b0;
        write_cfg(9'b00_000_0_0_00);
        window(6, nh, nv, ni);

        // R12 embedded codes
        write_cfg(9'b00_111_0_0_00);
        window(6, nh, nv, ni);
        check("R12", "field follows code_field", field_out, 0);
        hs_pin = 1'b1;
        window(6, nh, nv, ni);
        check("R12", "pins ignored h_strobe", nh, 0);
        code_h = 1'b1;
        window(1, nh, nv, ni);
        code_h = 1'b0;
        window(5, ah, av, ai);
        check("R12", "code_h strobe", nh + ah, 1);
        code_v = 1'b1;
        window(1, nh, nv, ni);
        code_v = 1'b0;
        window(5, ah, av, ai);
        check("R12", "code_v strobe", nv + av, 1);
        code_field = 1'b1;
        window(6, nh, nv, ni);
        check("R12", "field tracks code", field_out, 1);
        code_disable = 1'b1;
        hs_pin = 1'b0;
        window(6, nh, nv, ni);
        vs_pin = 1'b1;
        window(6, nh, nv, ni);
        check("R12", "override v_strobe", nv, 1);
        check("R12", "override field from HS", field_out, 0);
        hs_pin = 1'b1;
        window(6, nh, nv, ni);
        check("R12", "override h_strobe", nh, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule